// File: doc/BRIEF.md
# Sequential Multiply/Divide Peripheral

This peripheral gives a small processor unsigned 32-by-16 division and 16-by-16 multiplication without tying up the core. Software loads a 32-bit operand register A (written as two 16-bit halves) and a 16-bit operand register B. It then writes the control register, choosing the operation with the mode bit and launching it with the enable bit. The unit runs a fixed number of internal clocks that does not depend on the data. The result overwrites the operands in place: the quotient or product goes into A and the remainder into a separate remainder register. The enable bit then drops by itself, and a one-cycle interrupt pulse follows.

All access goes through one word-wide port with a 3-bit address. Writes are taken on the clock edge. Reads are combinational from the address. While an operation is in flight the bus cannot disturb the operands or the control state.

Top module: `mdu_unit`

## Requirements
- R1: After a synchronous active-low reset, registers A, B, the remainder and the control register all read 0, and `irq` is 0.
- R2: The address map is 0 = A low half, 1 = A high half, 2 = B, 3 = remainder, 4 = control. Control bit 0 holds the mode (0 = divide, 1 = multiply) and bit 7 reads as the enable. A control write while idle stores bit 0, and it starts an operation only if bit 7 is 1.
- R3: Once started, the enable bit reads 1 for exactly 32 clocks for a division and exactly 16 clocks for a multiplication.
- R4: When a division ends, A holds the unsigned quotient of the old A divided by B, and the remainder register holds the unsigned remainder.
- R5: With B = 0, a division still takes 32 clocks and ends with A = 0xFFFFFFFF and the remainder equal to the old low half of A.
- R6: The enable bit clears by itself at the end of an operation. `irq` is high for exactly one clock, the clock after the first clock in which the enable reads 0.
- R7: While the enable bit reads 1, writes to A, B and the control register have no effect.
- R8: When a multiplication ends, A holds the 32-bit product of the old low half of A and B, and the remainder register is unchanged.
- R9: Writes to the remainder address are ignored. Reads of addresses 5 to 7 return 0.
- R10: A start write made in the same clock that `irq` is high is accepted, and that operation's interrupt arrives at its normal time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Two events can land in the same clock. The first is the interrupt pulse of a finished operation and the control write that launches the next one. The second is the last busy clock of an operation and a bus write aimed at the operand registers. The bench provokes the first by waiting until `irq` is seen high and issuing a start write in that same cycle. It provokes the second with back-to-back operand writes that straddle the enable falling edge. Both cases are judged against the cycle-by-cycle model, which accepts the writes only once the enable reads 0 and expects exactly one interrupt per operation at its fixed offset.

// File: rtl/mdu_pkg.sv
// Package: shared register addresses and control bit positions of the
// multiply/divide peripheral. Assumes a 3-bit word address.
package mdu_pkg;
    localparam int        HALF_W   = 16;
    localparam int        ADDR_W   = 3;
    localparam logic [2:0] ADR_A_LO = 3'd0;
    localparam logic [2:0] ADR_A_HI = 3'd1;
    localparam logic [2:0] ADR_B    = 3'd2;
    localparam logic [2:0] ADR_REM  = 3'd3;
    localparam logic [2:0] ADR_CTRL = 3'd4;
    localparam int        BIT_MODE = 0;
    localparam int        BIT_EN   = 7;
endpackage

// File: rtl/mdu_ctrl.sv
// Module: sequencing of one operation. It holds the mode and enable bits,
// counts a fixed number of steps and emits the delayed one-cycle interrupt.
// Assumes start_i only arrives while busy_o is low.
module mdu_ctrl #(
    parameter int DIV_STEPS = 32,
    parameter int MUL_STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr_i,
    input  logic mode_d_i,
    input  logic start_i,
    output logic busy_o,
    output logic mode_o,
    output logic irq_o
);
    localparam int CW = $clog2(DIV_STEPS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          last;
    logic          pend;

    // Index of the final step for the current mode.
    always_comb begin
        lim  = mode_o ? CW'(MUL_STEPS - 1) : CW'(DIV_STEPS - 1);
        last = busy_o && (cnt == lim);
    end

    // Mode storage, step counter, busy flag and interrupt pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= 1'b0;
            busy_o <= 1'b0;
            cnt    <= '0;
            pend   <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (mode_wr_i) begin
                mode_o <= mode_d_i;
            end
            if (start_i) begin
                busy_o <= 1'b1;
                cnt    <= '0;
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
                if (last) begin
                    busy_o <= 1'b0;
                end
            end
            pend  <= last;
            irq_o <= pend;
        end
    end
endmodule

// File: rtl/mdu_datapath.sv
// Module: operand and result storage plus one iteration step per clock.
// Division is restoring shift-subtract with the quotient shifted into A.
// Multiplication is shift-add with the product built in A.
// Assumes bus writes are already gated off while busy.
module mdu_datapath #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ok_i,
    input  logic [2:0]      addr_i,
    input  logic [HW-1:0]   wdata_i,
    input  logic            start_i,
    input  logic            start_mode_i,
    input  logic            busy_i,
    input  logic            mode_i,
    output logic [2*HW-1:0] a_o,
    output logic [HW-1:0]   b_o,
    output logic [HW-1:0]   rem_o
);
    import mdu_pkg::*;

    logic [HW:0]     trial;
    logic            ge;
    logic [HW:0]     diff;
    logic [HW-1:0]   div_rem;
    logic [2*HW-1:0] div_a;
    logic [HW-1:0]   addend;
    logic [HW:0]     sum;
    logic [2*HW-1:0] mul_a;

    // One restoring division step: shift in the next dividend bit, try the subtract.
    always_comb begin
        trial   = {rem_o, a_o[2*HW-1]};
        ge      = trial >= {1'b0, b_o};
        diff    = trial - {1'b0, b_o};
        div_rem = ge ? diff[HW-1:0] : trial[HW-1:0];
        div_a   = {a_o[2*HW-2:0], ge};
    end

    // One multiply step: add B to the high half if the low bit is set, shift right.
    always_comb begin
        addend = a_o[0] ? b_o : '0;
        sum    = {1'b0, a_o[2*HW-1:HW]} + {1'b0, addend};
        mul_a  = {sum, a_o[HW-1:1]};
    end

    // Register update: initialise on start, iterate while busy, else accept bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o   <= '0;
            b_o   <= '0;
            rem_o <= '0;
        end else if (start_i) begin
            if (start_mode_i) begin
                a_o[2*HW-1:HW] <= '0;
            end else begin
                rem_o <= '0;
            end
        end else if (busy_i) begin
            if (mode_i) begin
                a_o <= mul_a;
            end else begin
                a_o   <= div_a;
                rem_o <= div_rem;
            end
        end else if (wr_ok_i) begin
            case (addr_i)
                ADR_A_LO: a_o[HW-1:0]    <= wdata_i;
                ADR_A_HI: a_o[2*HW-1:HW] <= wdata_i;
                ADR_B:    b_o            <= wdata_i;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/mdu_unit.sv
// Module: top of the multiply/divide peripheral. It gates bus writes while an
// operation runs, decodes the start write and drives the read mux.
// Assumes HW >= 8 so that the control bits fit in a word.
module mdu_unit #(
    parameter int HW = mdu_pkg::HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [HW-1:0] wdata,
    output logic [HW-1:0] rd_data,
    output logic          irq
);
    import mdu_pkg::*;

    localparam int DIV_STEPS = 2 * HW;
    localparam int MUL_STEPS = HW;

    logic            busy;
    logic            mode;
    logic            wr_ok;
    logic            ctrl_wr;
    logic            start;
    logic [2*HW-1:0] a_q;
    logic [HW-1:0]   b_q;
    logic [HW-1:0]   rem_q;

    // Bus write qualification and start decode.
    always_comb begin
        wr_ok   = wr_en && !busy;
        ctrl_wr = wr_ok && (addr == ADR_CTRL);
        start   = ctrl_wr && wdata[BIT_EN];
    end

    mdu_ctrl #(
        .DIV_STEPS(DIV_STEPS),
        .MUL_STEPS(MUL_STEPS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr_i(ctrl_wr),
        .mode_d_i (wdata[BIT_MODE]),
        .start_i  (start),
        .busy_o   (busy),
        .mode_o   (mode),
        .irq_o    (irq)
    );

    mdu_datapath #(
        .HW(HW)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ok_i     (wr_ok),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .start_i     (start),
        .start_mode_i(wdata[BIT_MODE]),
        .busy_i      (busy),
        .mode_i      (mode),
        .a_o         (a_q),
        .b_o         (b_q),
        .rem_o       (rem_q)
    );

    // Read mux: registers by address, zero for unused addresses.
    always_comb begin
        rd_data = '0;
        case (addr)
            ADR_A_LO: rd_data = a_q[HW-1:0];
            ADR_A_HI: rd_data = a_q[2*HW-1:HW];
            ADR_B:    rd_data = b_q;
            ADR_REM:  rd_data = rem_q;
            ADR_CTRL: begin
                rd_data[BIT_EN]   = busy;
                rd_data[BIT_MODE] = mode;
            end
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdu_unit_chk.sv
// Module: assertion checker bound to mdu_unit. It watches the start decode,
// the busy length, the interrupt timing and the frozen state during a run.
module mdu_unit_chk #(
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [HW-1:0] wdata,
    input logic          busy,
    input logic          mode,
    input logic          irq,
    input logic [HW-1:0] b_reg
);
    localparam int CW = $clog2(2 * HW + 1);

    logic [CW-1:0] run_len;

    // Length of the current or just-ended busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr == 3'd4 && wdata[7]) |=> busy); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == (mode ? CW'(HW) : CW'(2 * HW)))); // R3
    AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> irq); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_B_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(b_reg)); // R7
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode)); // R7
endmodule

bind mdu_unit mdu_unit_chk #(.HW(HW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .busy (busy),
    .mode (mode),
    .irq  (irq),
    .b_reg(b_q)
);

// File: tb/mdu_unit_bench.sv
// Bench: a behavioural reference model is stepped on every rising edge and
// compared with the design a quarter period later.
module mdu_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        irq;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 1'b0;
    string ctx = "R1";

    logic [31:0] m_a, r_a;
    logic [15:0] m_b, m_rem, r_rem;
    bit          m_busy, m_mode, m_pend, m_irq;
    int          m_left;

    mdu_unit u_mdu_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rd_data(rd_data),
        .irq    (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_a[15:0];
            3'd1: return m_a[31:16];
            3'd2: return m_b;
            3'd3: return m_rem;
            3'd4: return {8'h00, m_busy, 6'h00, m_mode};
            default: return 16'h0000;
        endcase
    endfunction

    // Reference model step at the edge, then a comparison away from the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = '0; m_b = '0; m_rem = '0;
            m_busy = 0; m_mode = 0; m_pend = 0; m_irq = 0; m_left = 0;
        end else begin
            m_irq  = m_pend;
            m_pend = m_busy && (m_left == 1);
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_a    = r_a;
                    m_rem  = r_rem;
                end
            end else if (wr_en) begin
                case (addr)
                    3'd0: m_a[15:0]  = wdata;
                    3'd1: m_a[31:16] = wdata;
                    3'd2: m_b        = wdata;
                    3'd4: begin
                        m_mode = wdata[0];
                        if (wdata[7]) begin
                            m_busy = 1;
                            if (m_mode) begin
                                m_left = 16;
                                r_a    = 32'(m_a[15:0]) * 32'(m_b);
                                r_rem  = m_rem;
                            end else begin
                                m_left = 32;
                                if (m_b == 0) begin
                                    r_a   = 32'hFFFF_FFFF;
                                    r_rem = m_a[15:0];
                                end else begin
                                    r_a   = m_a / 32'(m_b);
                                    r_rem = 16'(m_a % 32'(m_b));
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
        #(CLK_PERIOD / 4);
        if (rst_n && !finished) begin
            chk(ctx, "irq (R6)", 32'(irq), 32'(m_irq));
            if (!(m_busy && (addr == 3'd0 || addr == 3'd1 || addr == 3'd3)))
                chk(ctx, $sformatf("rd_data addr %0d", addr), 32'(rd_data), 32'(model_rd(addr)));
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(logic [2:0] a, int n);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic load(logic [31:0] a, logic [15:0] b);
        wr(3'd0, a[15:0]);
        wr(3'd1, a[31:16]);
        wr(3'd2, b);
    endtask

    task automatic read_all();
        for (int i = 0; i < 5; i++) look(3'(i), 1);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctx = "R1";
        @(negedge clk);
        chk("R1", "irq after reset", 32'(irq), 32'd0);
        for (int i = 0; i < 8; i++) look(3'(i), 1);

        ctx = "R2";   // mode write without enable: no start
        wr(3'd4, 16'h0001);
        look(3'd4, 4);

        ctx = "R4";   // plain division, busy length R3 watched on control
        load(32'h1234_5678, 16'h1234);
        wr(3'd4, 16'h0080);
        look(3'd4, 36);
        read_all();

        ctx = "R8";   // multiply, largest operands
        load(32'h0000_FFFF, 16'hFFFF);
        wr(3'd4, 16'h0081);
        look(3'd4, 20);
        read_all();

        ctx = "R5";   // divide by zero
        load(32'hDEAD_BEEF, 16'h0000);
        wr(3'd4, 16'h0080);
        look(3'd4, 36);
        read_all();

        ctx = "R3";   // quotient exceeding 16 bits, zero remainder
        load(32'hFFFF_FFFF, 16'hFFFF);
        wr(3'd4, 16'h0080);
        look(3'd4, 36);
        read_all();

        ctx = "R7";   // writes during busy, some straddling the end
        load(32'h0001_0000, 16'h0003);
        wr(3'd4, 16'h0080);
        wr(3'd2, 16'h0007);
        wr(3'd4, 16'h0081);
        look(3'd4, 26);
        for (int i = 0; i < 5; i++) wr(3'd0, 16'hAAA0 + 16'(i));
        look(3'd4, 4);
        read_all();

        ctx = "R9";
        wr(3'd3, 16'h5555);
        read_all();

        ctx = "R10";  // restart in the interrupt cycle
        load(32'h0000_0064, 16'h0007);
        wr(3'd4, 16'h0080);
        addr = 3'd4;
        while (!irq) @(negedge clk);
        wr(3'd4, 16'h0080);
        look(3'd4, 36);
        read_all();

        finished = 1'b1;
        report();
        $finish;
    end
endmodule